// File: doc/BRIEF.md
# Barrel Shift and Bitfield Unit

This execution unit serves a 32-bit soft processor. It takes one instruction word together with operand A, operand B and the current value of the destination register. It decodes the word and performs one of five operations. The first three are shifts: logical right, arithmetic right and left. Each shift takes its amount from operand B or from a 5-bit immediate. The other two are bitfield operations with immediate parameters: extracting a field and inserting a field.

The result and its flags are registered. They appear one cycle after an input strobe, together with a valid output. A write-enable tells the pipeline to commit the result. The illegal flag marks an encoding that is malformed, or any barrel opcode when the unit is configured off. The undefined-input flag marks bitfield parameters that have no defined meaning. Whenever write-enable is low, the result simply echoes the destination value, so nothing changes.

Top module: `barrel_bitfield_unit`

## Requirements
- R1: Major opcode 010001 (bits [31:26]) is the register-amount shift. Its low 11 bits select the operation: 0x000 is logical right, 0x200 is arithmetic right and 0x400 is left. The amount is operand B masked to bits [4:0], and write-enable is high.
- R2: Major opcode 011001 with bits [15:11]=00000 is the immediate shift. Bits [10:5] select the operation: 000000 is logical right, 010000 is arithmetic right and 100000 is left. The amount is bits [4:0].
- R3: Major opcode 011001 with bits [15:11]=01000 and bit 5=0 is extract. Let W be bits [10:6] and S be bits [4:0]. The result is operand A shifted right by S, keeping only the low W bits, with the rest zero.
- R4: An extract with W=0, or with W+S greater than 32, raises the undefined flag and keeps write-enable low.
- R5: Major opcode 011001 with bits [15:11]=10000 and bit 5=0 is insert. The result is the destination value with bits S through W replaced by the low W-S+1 bits of operand A.
- R6: An insert with W less than S raises the undefined flag and keeps write-enable low.
- R7: Any other encoding under the two barrel opcodes raises the illegal flag. This includes low 11 bits that match no register form, and bit 5 set in a bitfield form.
- R8: With the ENABLE parameter at 0, every word carrying either barrel opcode raises the illegal flag and never write-enable.
- R9: The result and the flags appear on the cycle after an in_valid strobe, with out_valid high for exactly that cycle. While out_valid is low, all three flags are low.
- R10: At most one of write-enable, illegal and undefined is high. When write-enable is low on a valid output, the result equals the destination value that was presented. Words with any other major opcode produce no flag at all.
- R11: After synchronous reset, out_valid, all flags and the result are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input strobe |
| instr | input | 32 | Instruction word |
| opa | input | 32 | Operand A |
| opb | input | 32 | Operand B (register shift amount) |
| dst_in | input | 32 | Current destination value |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| result | output | 32 | Result data |
| wr_en | output | 1 | Commit result to destination |
| illegal | output | 1 | Illegal instruction indication |
| undef_in | output | 1 | Undefined bitfield parameters |

## Verification
Several properties are checked on every cycle: the one-cycle alignment of out_valid with the strobe, quiet flags while idle, mutual exclusion of the three flags, and the destination echo whenever nothing is written. Two further checks run every cycle as well: the illegal response of a disabled unit, and the rule that the undefined flag only ever follows an immediate-form word. The actual shift and field arithmetic, the masking of the amount to five bits, and the exact boundaries of the undefined conditions (W+S equal to 32 against 33, W equal to S, the full-width insert) can only be shown by the bench. It drives directed and random words and compares them against its behavioural model, using one enabled and one disabled instance.

// File: rtl/bsu_pkg.sv
package bsu_pkg;
    localparam int DATA_W  = 32;
    localparam int INSTR_W = 32;
    localparam int FLD_W   = $clog2(DATA_W);
    localparam logic [5:0] MAJ_REG = 6'b010001;
    localparam logic [5:0] MAJ_IMM = 6'b011001;
    localparam logic [4:0] CLS_SHIFT = 5'b00000;
    localparam logic [4:0] CLS_EXT   = 5'b01000;
    localparam logic [4:0] CLS_INS   = 5'b10000;

    typedef enum logic [2:0] {
        OP_NONE, OP_LSR, OP_ASR, OP_LSL, OP_EXT, OP_INS, OP_BAD
    } op_e;

    typedef struct packed {
        op_e              op;
        logic             imm_amt;
        logic [FLD_W-1:0] lo;
        logic [FLD_W-1:0] hi;
    } dec_t;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              wr;
        logic              ill;
        logic              und;
    } res_t;

    function automatic logic is_barrel(input logic [INSTR_W-1:0] ins);
        return (ins[31:26] == MAJ_REG) || (ins[31:26] == MAJ_IMM);
    endfunction

    // ones from bit lo up to bit hi inclusive (hi >= lo)
    function automatic logic [DATA_W-1:0] span_mask(input logic [FLD_W-1:0] lo,
                                                    input logic [FLD_W-1:0] hi);
        logic [DATA_W-1:0] ones;
        ones = '1;
        return (ones << lo) & (ones >> (FLD_W'(DATA_W - 1) - hi));
    endfunction
endpackage

// File: rtl/bsu_decode.sv
module bsu_decode
    import bsu_pkg::*;
#(
    parameter bit ENABLE = 1'b1
) (
    input  logic [INSTR_W-1:0] instr,
    output dec_t               dec
);
    logic [5:0] major;
    logic [4:0] cls;
    logic [5:0] sub;
    op_e        raw_op;

    assign major = instr[31:26];
    assign cls   = instr[15:11];
    assign sub   = instr[10:5];

    always_comb begin
        raw_op = OP_NONE;
        if (major == MAJ_REG) begin
            case (instr[10:0])
                11'h000: raw_op = OP_LSR;
                11'h200: raw_op = OP_ASR;
                11'h400: raw_op = OP_LSL;
                default: raw_op = OP_BAD;
            endcase
        end else if (major == MAJ_IMM) begin
            if (cls == CLS_SHIFT && sub == 6'b000000)      raw_op = OP_LSR;
            else if (cls == CLS_SHIFT && sub == 6'b010000) raw_op = OP_ASR;
            else if (cls == CLS_SHIFT && sub == 6'b100000) raw_op = OP_LSL;
            else if (cls == CLS_EXT && !instr[5])          raw_op = OP_EXT;
            else if (cls == CLS_INS && !instr[5])          raw_op = OP_INS;
            else                                           raw_op = OP_BAD;
        end
    end

    generate
        if (ENABLE) begin : g_on
            assign dec.op = raw_op;
        end else begin : g_off
            assign dec.op = (raw_op == OP_NONE) ? OP_NONE : OP_BAD;
        end
    endgenerate

    assign dec.imm_amt = (major == MAJ_IMM);
    assign dec.lo      = instr[FLD_W-1:0];
    assign dec.hi      = instr[6+FLD_W-1:6];
endmodule

// File: rtl/bsu_exec.sv
module bsu_exec
    import bsu_pkg::*;
(
    input  dec_t              dec,
    input  logic [DATA_W-1:0] opa,
    input  logic [FLD_W-1:0]  opb_amt,
    input  logic [DATA_W-1:0] dst,
    output res_t              res
);
    logic [FLD_W-1:0]  amt;
    logic [FLD_W:0]    ext_end;
    logic [DATA_W-1:0] ins_mask;
    logic [DATA_W-1:0] ones;

    assign ones     = '1;
    assign amt      = dec.imm_amt ? dec.lo : opb_amt;
    assign ext_end  = {1'b0, dec.hi} + {1'b0, dec.lo};
    assign ins_mask = span_mask(dec.lo, dec.hi);

    always_comb begin
        res      = '0;
        res.data = dst;
        case (dec.op)
            OP_LSR: begin res.data = opa >> amt; res.wr = 1'b1; end
            OP_ASR: begin res.data = DATA_W'($signed(opa) >>> amt); res.wr = 1'b1; end
            OP_LSL: begin res.data = opa << amt; res.wr = 1'b1; end
            OP_EXT: begin
                if (dec.hi == '0 || ext_end > (FLD_W+1)'(DATA_W)) begin
                    res.und = 1'b1;
                end else begin
                    res.data = (opa >> dec.lo) & ~(ones << dec.hi);
                    res.wr   = 1'b1;
                end
            end
            OP_INS: begin
                if (dec.hi < dec.lo) begin
                    res.und = 1'b1;
                end else begin
                    res.data = (dst & ~ins_mask) | ((opa << dec.lo) & ins_mask);
                    res.wr   = 1'b1;
                end
            end
            OP_BAD:  res.ill = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/barrel_bitfield_unit.sv
module barrel_bitfield_unit
    import bsu_pkg::*;
#(
    parameter bit ENABLE = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [31:0]       instr,
    input  logic [31:0]       opa,
    input  logic [31:0]       opb,
    input  logic [31:0]       dst_in,
    output logic              out_valid,
    output logic [31:0]       result,
    output logic              wr_en,
    output logic              illegal,
    output logic              undef_in
);
    dec_t dec;
    res_t res_c;
    res_t res_q;
    logic vld_q;

    bsu_decode #(.ENABLE(ENABLE)) u_dec (
        .instr (instr),
        .dec   (dec)
    );

    bsu_exec u_exec (
        .dec     (dec),
        .opa     (opa),
        .opb_amt (opb[FLD_W-1:0]),
        .dst     (dst_in),
        .res     (res_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            res_q <= '0;
        end else begin
            vld_q <= in_valid;
            if (in_valid) begin
                res_q <= res_c;
            end else begin
                res_q.wr  <= 1'b0;
                res_q.ill <= 1'b0;
                res_q.und <= 1'b0;
            end
        end
    end

    assign out_valid = vld_q;
    assign result    = res_q.data;
    assign wr_en     = res_q.wr;
    assign illegal   = res_q.ill;
    assign undef_in  = res_q.und;

    // R9
    valid_rise_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    // R9
    valid_fall_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> !(wr_en || illegal || undef_in));
    // R10
    flag_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({wr_en, illegal, undef_in}));
    // R10
    hold_dst_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid ##1 (out_valid && !wr_en) |-> result == $past(dst_in));
    // R8
    off_illegal_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !ENABLE && is_barrel(instr)) |=> (illegal && !wr_en));
    // R4 R6
    und_source_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid ##1 undef_in |-> $past(instr[31:26]) == MAJ_IMM);
endmodule

// File: tb/test_barrel_bitfield_unit.sv
module test_barrel_bitfield_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] instr = '0, opa = '0, opb = '0, dst_in = '0;
    logic        ov_a, we_a, il_a, ud_a, ov_b, we_b, il_b, ud_b;
    logic [31:0] res_a, res_b;
    int checks = 0, errors = 0;
    bit done = 0;
    logic [34:0] exp_a = '0, exp_b = '0;
    logic        exp_v = 1'b0;

    always #10 clk = ~clk;

    barrel_bitfield_unit #(.ENABLE(1'b1)) i_barrel_bitfield_unit (
        .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr), .opa(opa),
        .opb(opb), .dst_in(dst_in), .out_valid(ov_a), .result(res_a),
        .wr_en(we_a), .illegal(il_a), .undef_in(ud_a));

    barrel_bitfield_unit #(.ENABLE(1'b0)) i_barrel_bitfield_unit_off (
        .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr), .opa(opa),
        .opb(opb), .dst_in(dst_in), .out_valid(ov_b), .result(res_b),
        .wr_en(we_b), .illegal(il_b), .undef_in(ud_b));

    // returns {data, wr, ill, und}
    function automatic logic [34:0] model(input bit en, input logic [31:0] w,
                                          input logic [31:0] a, input logic [31:0] b,
                                          input logic [31:0] d);
        logic [31:0] r;
        int amt, kind, fw, fs;
        r = d;
        kind = 0; // 1 lsr 2 asr 3 lsl 4 ext 5 ins 6 bad
        amt = 0;
        fw = int'(w[10:6]);
        fs = int'(w[4:0]);
        if (w[31:26] == 6'b010001) begin
            amt = int'(b[4:0]);
            if (w[10:0] == 11'h000) kind = 1;
            else if (w[10:0] == 11'h200) kind = 2;
            else if (w[10:0] == 11'h400) kind = 3;
            else kind = 6;
        end else if (w[31:26] == 6'b011001) begin
            amt = fs;
            if (w[15:11] == 5'b00000 && w[10:5] == 6'b000000) kind = 1;
            else if (w[15:11] == 5'b00000 && w[10:5] == 6'b010000) kind = 2;
            else if (w[15:11] == 5'b00000 && w[10:5] == 6'b100000) kind = 3;
            else if (w[15:11] == 5'b01000 && !w[5]) kind = 4;
            else if (w[15:11] == 5'b10000 && !w[5]) kind = 5;
            else kind = 6;
        end
        if (!en && kind != 0) kind = 6;
        case (kind)
            1, 2: begin
                for (int i = 0; i < 32; i++)
                    r[i] = (i + amt < 32) ? a[i+amt] : ((kind == 2) ? a[31] : 1'b0);
                return {r, 3'b100};
            end
            3: begin
                for (int i = 0; i < 32; i++) r[i] = (i >= amt) ? a[i-amt] : 1'b0;
                return {r, 3'b100};
            end
            4: begin
                if (fw == 0 || fw + fs > 32) return {d, 3'b001};
                r = '0;
                for (int i = 0; i < fw; i++) r[i] = a[fs+i];
                return {r, 3'b100};
            end
            5: begin
                if (fw < fs) return {d, 3'b001};
                for (int i = fs; i <= fw; i++) r[i] = a[i-fs];
                return {r, 3'b100};
            end
            6: return {d, 3'b010};
            default: return {d, 3'b000};
        endcase
    endfunction

    function automatic logic [31:0] enc_reg(input logic [10:0] low);
        return {6'b010001, 5'd3, 5'd4, 5'd5, low};
    endfunction
    function automatic logic [31:0] enc_imm(input logic [4:0] cls, input logic [5:0] mid,
                                            input logic [4:0] lo);
        return {6'b011001, 5'd3, 5'd4, cls, mid, lo};
    endfunction
    function automatic logic [31:0] enc_fld(input logic [4:0] cls, input logic [4:0] w,
                                            input logic [4:0] s);
        return {6'b011001, 5'd3, 5'd4, cls, w, 1'b0, s};
    endfunction

    task automatic compare(input string tag, input string who, input logic ov,
                           input logic [31:0] r, input logic we, input logic il,
                           input logic ud, input logic [34:0] e, input logic ev);
        checks++;
        if (ov !== ev || r !== e[34:3] || {we, il, ud} !== e[2:0]) begin
            errors++;
            $display("FAIL %s %s: got v=%b res=%h we/ill/und=%b%b%b exp v=%b res=%h we/ill/und=%b",
                     tag, who, ov, r, we, il, ud, ev, e[34:3], e[2:0]);
        end
    endtask

    task automatic step(input logic v, input logic [31:0] w, input logic [31:0] a,
                        input logic [31:0] b, input logic [31:0] d, input string tag);
        in_valid = v; instr = w; opa = a; opb = b; dst_in = d;
        exp_v = v;
        if (v) begin
            exp_a = model(1'b1, w, a, b, d);
            exp_b = model(1'b0, w, a, b, d);
        end else begin
            exp_a[2:0] = 3'b000;
            exp_b[2:0] = 3'b000;
        end
        @(negedge clk);
        compare(tag, "on", ov_a, res_a, we_a, il_a, ud_a, exp_a, exp_v);
        compare((v && w[31:27] == 5'b01100 && w[25:0] != 0) || (v && (w[31:26] == 6'b010001 || w[31:26] == 6'b011001)) ? "R8" : tag,
                "off", ov_b, res_b, we_b, il_b, ud_b, exp_b, exp_v);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        compare("R11", "on", ov_a, res_a, we_a, il_a, ud_a, 35'd0, 1'b0);
        compare("R11", "off", ov_b, res_b, we_b, il_b, ud_b, 35'd0, 1'b0);
        rst = 1'b0;
        // R1 register-amount shifts, amount masked to five bits
        step(1, enc_reg(11'h000), 32'h8000_0000, 32'h0000_0021, 32'hAAAA_AAAA, "R1");
        step(1, enc_reg(11'h200), 32'h8765_4321, 32'd4, 32'h0, "R1");
        step(1, enc_reg(11'h400), 32'h0000_0003, 32'hFFFF_FFFF, 32'h0, "R1");
        step(1, enc_reg(11'h200), 32'h7000_0000, 32'd31, 32'h0, "R1");
        // R9 idle cycle
        step(0, 32'h0, 32'h0, 32'h0, 32'h0, "R9");
        // R2 immediate shifts
        step(1, enc_imm(5'b00000, 6'b000000, 5'd17), 32'hF0F0_1234, 32'd0, 32'h0, "R2");
        step(1, enc_imm(5'b00000, 6'b010000, 5'd0), 32'h8000_0001, 32'd9, 32'h0, "R2");
        step(1, enc_imm(5'b00000, 6'b100000, 5'd31), 32'h0000_0001, 32'd0, 32'h0, "R2");
        // R3 extract, including W+S exactly 32
        step(1, enc_fld(5'b01000, 5'd8, 5'd4), 32'h1234_5678, 32'd0, 32'hFFFF_FFFF, "R3");
        step(1, enc_fld(5'b01000, 5'd16, 5'd16), 32'hBEEF_0000, 32'd0, 32'h0, "R3");
        step(1, enc_fld(5'b01000, 5'd31, 5'd1), 32'hFFFF_FFFF, 32'd0, 32'h0, "R3");
        // R4 extract undefined
        step(1, enc_fld(5'b01000, 5'd0, 5'd3), 32'hFFFF_FFFF, 32'd0, 32'h1357_9BDF, "R4");
        step(1, enc_fld(5'b01000, 5'd20, 5'd13), 32'hFFFF_FFFF, 32'd0, 32'h0246_8ACE, "R4");
        // R5 insert: middle, full width, single bit
        step(1, enc_fld(5'b10000, 5'd15, 5'd8), 32'h0000_00AB, 32'd0, 32'hFFFF_FFFF, "R5");
        step(1, enc_fld(5'b10000, 5'd31, 5'd0), 32'hCAFE_F00D, 32'd0, 32'h1111_1111, "R5");
        step(1, enc_fld(5'b10000, 5'd31, 5'd31), 32'h0000_0001, 32'd0, 32'h0000_0000, "R5");
        // R6 insert undefined
        step(1, enc_fld(5'b10000, 5'd3, 5'd4), 32'hFFFF_FFFF, 32'd0, 32'h5555_5555, "R6");
        // R7 malformed encodings
        step(1, enc_reg(11'h600), 32'h1, 32'd1, 32'h7777_7777, "R7");
        step(1, enc_reg(11'h001), 32'h1, 32'd1, 32'h7777_7777, "R7");
        step(1, enc_imm(5'b01000, 6'b001001, 5'd2), 32'h1, 32'd0, 32'h6666_6666, "R7");
        step(1, enc_imm(5'b11000, 6'b000000, 5'd2), 32'h1, 32'd0, 32'h6666_6666, "R7");
        step(1, enc_imm(5'b00000, 6'b110000, 5'd2), 32'h1, 32'd0, 32'h6666_6666, "R7");
        // R10 unrelated opcode
        step(1, 32'h0000_1234, 32'hFFFF_FFFF, 32'd3, 32'h9999_0000, "R10");
        step(0, 32'h0, 32'h0, 32'h0, 32'h0, "R9");
        // random mix
        for (int n = 0; n < 400; n++) begin
            logic [31:0] w;
            int pick;
            pick = int'($urandom_range(0, 5));
            w = $urandom;
            case (pick)
                0: w = enc_reg({$urandom_range(0, 2) == 0 ? 3'b000 : ($urandom_range(0, 1) ? 3'b010 : 3'b100), 8'h00});
                1: w = enc_imm(5'b00000, {$urandom_range(0, 1) ? 2'b10 : 2'b01, 4'b0000}, 5'($urandom));
                2: w = enc_fld(5'b01000, 5'($urandom), 5'($urandom));
                3: w = enc_fld(5'b10000, 5'($urandom), 5'($urandom));
                4: w = {$urandom_range(0, 1) ? 6'b010001 : 6'b011001, 26'($urandom)};
                default: ;
            endcase
            step(1'($urandom_range(0, 3) != 0), w, $urandom, $urandom, $urandom, "R10");
        end
        step(0, 32'h0, 32'h0, 32'h0, 32'h0, "R9");
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got hang expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule